// File: doc/BRIEF.md
# JTAG Bus Monitor Decoder

This block listens to the four wires of a JTAG test access port (test clock, mode select, data in, data out) and never drives any of them. It oversamples the wires with a faster system clock, follows the sixteen-state TAP controller edge by edge, and signals the new controller state after every rising test-clock edge.

While the controller loops in a shift state, it collects the data-in and data-out bits into two vectors. When the shift ends, it hands out one scan record. The record carries an instruction/data flag, both vectors, a bit count and an overflow flag. Records leave through a valid/ready handshake, so a slow consumer loses records rather than stalling the monitor.

Top module: `jtmon_top`

## Requirements
- R1: After a synchronous reset (`rst` high), `st_code_o` reads 1 (Run-Test/Idle). `st_valid_o`, `rec_valid_o` and `rec_lost_o` are 0.
- R2: State codes are: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. On each rising test-clock edge the state advances by the standard TAP transition table, using the mode-select value seen at that edge.
- R3: Falling test-clock edges cause no state change and no strobe. Neither do changes on mode select, data in or data out while the test clock is steady.
- R4: Every rising test-clock edge produces exactly one one-cycle pulse on `st_valid_o` carrying the new code, including edges that leave the state unchanged.
- R5: A data-in/data-out pair is captured only on a rising edge whose old and new states are the same shift state. The edge that enters shift (from Capture or Exit2) captures nothing, and so does the edge that leaves shift. A pass through Pause therefore ends one record and starts another.
- R6: The first captured bit is at bit 0 of `rec_tdi_o`/`rec_tdo_o`, and later bits follow at rising positions. Positions at or above the bit count read 0.
- R7: An edge from Shift-DR to Exit1-DR, or from Shift-IR to Exit1-IR, emits one record. `rec_is_ir_o` is 1 for the IR branch and 0 for the DR branch. `rec_count_o` holds the number of captured bits. Capture-to-Exit1 emits nothing.
- R8: Bits beyond the `CAP_W` vector width are discarded, while the count keeps rising and stops at 2^`CNT_W`-1. `rec_ovf_o` is 1 exactly when a bit was discarded.
- R9: A record stays on the outputs, unchanged, until taken with `rec_ready_i`. A record that falls due while the previous one is still untaken is dropped, and `rec_lost_o` is set and stays set until reset.
- R10: Entering shift and leaving it on the next edge emits a record with count 0 and all-zero vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the test clock |
| rst | input | 1 | Synchronous active-high reset |
| tck_i | input | 1 | Observed test clock |
| tms_i | input | 1 | Observed mode select |
| tdi_i | input | 1 | Observed serial data into the device |
| tdo_i | input | 1 | Observed serial data out of the device |
| st_valid_o | output | 1 | One-cycle pulse per rising test-clock edge |
| st_code_o | output | 4 | Current controller state code |
| rec_valid_o | output | 1 | Scan record available |
| rec_ready_i | input | 1 | Consumer takes the record |
| rec_is_ir_o | output | 1 | 1 = instruction scan, 0 = data scan |
| rec_ovf_o | output | 1 | Bits were discarded in this record |
| rec_count_o | output | CNT_W | Captured bit count, saturating |
| rec_tdi_o | output | CAP_W | Data-in bits, first bit at bit 0 |
| rec_tdo_o | output | CAP_W | Data-out bits, first bit at bit 0 |
| rec_lost_o | output | 1 | Sticky: a record was dropped |

## Verification
The assertions check several properties on every cycle. The controller holds its state between rising edges. Shift and Test-Logic-Reset are entered only from legal predecessors. A pending record stays frozen until it is taken. The lost flag never clears. A record never appears except on arrival in an Exit1 state. A record without overflow never reports more bits than the vector holds. Only the bench scenarios can show the rest, by comparing each strobe and record against a model of the transition table:
- the full transition table itself;
- the bit ordering;
- the split of a scan around Pause;
- zero-length scans;
- count saturation past 255;
- which of two colliding records survives.

// File: rtl/jtmon_pkg.sv
package jtmon_pkg;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_SEL_DR   = 4'd2,
        ST_CAP_DR   = 4'd3,
        ST_SHIFT_DR = 4'd4,
        ST_EXIT1_DR = 4'd5,
        ST_PAUSE_DR = 4'd6,
        ST_EXIT2_DR = 4'd7,
        ST_UPD_DR   = 4'd8,
        ST_SEL_IR   = 4'd9,
        ST_CAP_IR   = 4'd10,
        ST_SHIFT_IR = 4'd11,
        ST_EXIT1_IR = 4'd12,
        ST_PAUSE_IR = 4'd13,
        ST_EXIT2_IR = 4'd14,
        ST_UPD_IR   = 4'd15
    } tap_state_e;

    // Sampled wire values at one system-clock cycle
    typedef struct packed {
        logic tck;
        logic tms;
        logic tdi;
        logic tdo;
    } wires_t;

    localparam int WIRE_W = $bits(wires_t);

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:    n = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   n = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   n = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: n = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: n = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: n = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: n = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   n = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   n = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   n = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: n = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: n = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: n = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: n = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            default:     n = tms ? ST_SEL_DR   : ST_IDLE;
        endcase
        return n;
    endfunction

    function automatic logic st_is_shift(tap_state_e s);
        return (s == ST_SHIFT_DR) || (s == ST_SHIFT_IR);
    endfunction

    function automatic logic st_is_exit1(tap_state_e s);
        return (s == ST_EXIT1_DR) || (s == ST_EXIT1_IR);
    endfunction

    function automatic logic st_in_ir(tap_state_e s);
        return s inside {ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR,
                         ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR};
    endfunction

endpackage

// File: rtl/jtmon_sync.sv
module jtmon_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/jtmon_tap.sv
module jtmon_tap
    import jtmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step_i,
    input  logic       tms_i,
    output tap_state_e state_o,
    output tap_state_e next_o,
    output logic       strobe_o
);
    tap_state_e state_q;
    logic       strobe_q;

    assign next_o = tap_next(state_q, tms_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= step_i;
            if (step_i) state_q <= next_o;
        end
    end

    assign state_o  = state_q;
    assign strobe_o = strobe_q;

    AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(state_q)); // R3

    AST_SHIFT_DR_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (strobe_q && state_q == ST_SHIFT_DR) |->
        ($past(state_q) inside {ST_CAP_DR, ST_EXIT2_DR, ST_SHIFT_DR})); // R2

    AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (strobe_q && state_q == ST_RESET) |->
        ($past(state_q) inside {ST_RESET, ST_SEL_IR})); // R2
endmodule

// File: rtl/jtmon_capture.sv
module jtmon_capture
    import jtmon_pkg::*;
#(
    parameter int CAP_W = 64,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  tap_state_e       cur_i,
    input  tap_state_e       nxt_i,
    input  logic             tdi_i,
    input  logic             tdo_i,
    input  logic             rec_ready_i,
    output logic             rec_valid_o,
    output logic             rec_is_ir_o,
    output logic             rec_ovf_o,
    output logic [CNT_W-1:0] rec_count_o,
    output logic [CAP_W-1:0] rec_tdi_o,
    output logic [CAP_W-1:0] rec_tdo_o,
    output logic             rec_lost_o
);
    localparam int               IDX_W   = (CAP_W > 1) ? $clog2(CAP_W) : 1;
    localparam logic [CNT_W:0]   CAP_LIM = (CNT_W+1)'(CAP_W);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CAP_W-1:0] acc_tdi_q, acc_tdo_q;
    logic [CNT_W-1:0] acc_cnt_q;
    logic             acc_ovf_q;

    logic take_bit, emit, room, blocked;

    assign take_bit = step_i && st_is_shift(cur_i) && (nxt_i == cur_i);
    assign emit     = step_i && st_is_shift(cur_i) && st_is_exit1(nxt_i);
    assign room     = ({1'b0, acc_cnt_q} < CAP_LIM);
    assign blocked  = rec_valid_o && !rec_ready_i;

    // Bit collection
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_tdi_q <= '0;
            acc_tdo_q <= '0;
            acc_cnt_q <= '0;
            acc_ovf_q <= 1'b0;
        end else if (emit) begin
            acc_tdi_q <= '0;
            acc_tdo_q <= '0;
            acc_cnt_q <= '0;
            acc_ovf_q <= 1'b0;
        end else if (take_bit) begin
            if (room) begin
                acc_tdi_q[acc_cnt_q[IDX_W-1:0]] <= tdi_i;
                acc_tdo_q[acc_cnt_q[IDX_W-1:0]] <= tdo_i;
            end else begin
                acc_ovf_q <= 1'b1;
            end
            if (acc_cnt_q != CNT_TOP) acc_cnt_q <= acc_cnt_q + 1'b1;
        end
    end

    // Record hand-off
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid_o <= 1'b0;
            rec_is_ir_o <= 1'b0;
            rec_ovf_o   <= 1'b0;
            rec_count_o <= '0;
            rec_tdi_o   <= '0;
            rec_tdo_o   <= '0;
            rec_lost_o  <= 1'b0;
        end else if (emit && blocked) begin
            rec_lost_o <= 1'b1;
        end else if (emit) begin
            rec_valid_o <= 1'b1;
            rec_is_ir_o <= st_in_ir(cur_i);
            rec_ovf_o   <= acc_ovf_q;
            rec_count_o <= acc_cnt_q;
            rec_tdi_o   <= acc_tdi_q;
            rec_tdo_o   <= acc_tdo_q;
        end else if (rec_valid_o && rec_ready_i) begin
            rec_valid_o <= 1'b0;
        end
    end

    AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && !rec_ready_i) |=>
        (rec_valid_o && $stable(rec_tdi_o) && $stable(rec_tdo_o) &&
         $stable(rec_count_o) && $stable(rec_is_ir_o))); // R9

    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst)
        rec_lost_o |=> rec_lost_o); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && !rec_ovf_o) |-> ({1'b0, rec_count_o} <= CAP_LIM)); // R8
endmodule

// File: rtl/jtmon_top.sv
module jtmon_top
    import jtmon_pkg::*;
#(
    parameter int CAP_W     = 64,
    parameter int CNT_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tck_i,
    input  logic             tms_i,
    input  logic             tdi_i,
    input  logic             tdo_i,
    output logic             st_valid_o,
    output logic [3:0]       st_code_o,
    output logic             rec_valid_o,
    input  logic             rec_ready_i,
    output logic             rec_is_ir_o,
    output logic             rec_ovf_o,
    output logic [CNT_W-1:0] rec_count_o,
    output logic [CAP_W-1:0] rec_tdi_o,
    output logic [CAP_W-1:0] rec_tdo_o,
    output logic             rec_lost_o
);
    wires_t     raw, synced;
    logic       tck_prev_q;
    logic       rise;
    tap_state_e cur_state, nxt_state;

    assign raw = '{tck: tck_i, tms: tms_i, tdi: tdi_i, tdo: tdo_i};

    jtmon_sync #(.WIDTH(WIRE_W), .STAGES(SYNC_STGS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (synced)
    );

    always_ff @(posedge clk) begin
        if (rst) tck_prev_q <= 1'b0;
        else     tck_prev_q <= synced.tck;
    end

    assign rise = synced.tck && !tck_prev_q;

    jtmon_tap u_tap (
        .clk      (clk),
        .rst      (rst),
        .step_i   (rise),
        .tms_i    (synced.tms),
        .state_o  (cur_state),
        .next_o   (nxt_state),
        .strobe_o (st_valid_o)
    );

    assign st_code_o = cur_state;

    jtmon_capture #(.CAP_W(CAP_W), .CNT_W(CNT_W)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .step_i      (rise),
        .cur_i       (cur_state),
        .nxt_i       (nxt_state),
        .tdi_i       (synced.tdi),
        .tdo_i       (synced.tdo),
        .rec_ready_i (rec_ready_i),
        .rec_valid_o (rec_valid_o),
        .rec_is_ir_o (rec_is_ir_o),
        .rec_ovf_o   (rec_ovf_o),
        .rec_count_o (rec_count_o),
        .rec_tdi_o   (rec_tdi_o),
        .rec_tdo_o   (rec_tdo_o),
        .rec_lost_o  (rec_lost_o)
    );

    AST_RECORD_AT_EXIT1: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid_o) |-> st_is_exit1(cur_state)); // R7
endmodule

// File: tb/tb_jtmon_top.sv
module tb_jtmon_top;
    localparam int CAP_W = 64;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, tck, tms, tdi, tdo, ready;
    logic             st_valid, rec_valid, rec_is_ir, rec_ovf, rec_lost;
    logic [3:0]       st_code;
    logic [CNT_W-1:0] rec_count;
    logic [CAP_W-1:0] rec_tdi, rec_tdo;

    jtmon_top #(.CAP_W(CAP_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .tck_i(tck), .tms_i(tms), .tdi_i(tdi), .tdo_i(tdo),
        .st_valid_o(st_valid), .st_code_o(st_code),
        .rec_valid_o(rec_valid), .rec_ready_i(ready),
        .rec_is_ir_o(rec_is_ir), .rec_ovf_o(rec_ovf), .rec_count_o(rec_count),
        .rec_tdi_o(rec_tdi), .rec_tdo_o(rec_tdo), .rec_lost_o(rec_lost)
    );

    int checks = 0;
    int errors = 0;
    int strobes = 0;

    // Scoreboard queues
    logic [3:0]       q_st[$];
    logic             q_ir[$];
    logic             q_ovf[$];
    logic [CNT_W-1:0] q_cnt[$];
    logic [CAP_W-1:0] q_tdi[$];
    logic [CAP_W-1:0] q_tdo[$];
    string            q_tag[$];

    // Reference model
    logic [3:0]       m_state = 4'd1;
    logic [CAP_W-1:0] m_tdi = '0, m_tdo = '0;
    int               m_cnt = 0;
    logic             m_ovf = 1'b0;
    bit               skip_next = 1'b0;
    string            cur_tag = "R2";

    task automatic check(string tag, string what, logic [CAP_W-1:0] act, logic [CAP_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [3:0] ref_next(logic [3:0] s, logic t);
        case (s)
            4'd0:  return t ? 4'd0  : 4'd1;
            4'd1:  return t ? 4'd2  : 4'd1;
            4'd2:  return t ? 4'd9  : 4'd3;
            4'd3:  return t ? 4'd5  : 4'd4;
            4'd4:  return t ? 4'd5  : 4'd4;
            4'd5:  return t ? 4'd8  : 4'd6;
            4'd6:  return t ? 4'd7  : 4'd6;
            4'd7:  return t ? 4'd8  : 4'd4;
            4'd8:  return t ? 4'd2  : 4'd1;
            4'd9:  return t ? 4'd0  : 4'd10;
            4'd10: return t ? 4'd12 : 4'd11;
            4'd11: return t ? 4'd12 : 4'd11;
            4'd12: return t ? 4'd15 : 4'd13;
            4'd13: return t ? 4'd14 : 4'd13;
            4'd14: return t ? 4'd15 : 4'd11;
            default: return t ? 4'd2 : 4'd1;
        endcase
    endfunction

    // One full test-clock period; the model runs at the rising edge
    task automatic tck_edge(logic t, logic di, logic dq);
        logic [3:0] nxt;
        bit shift;
        @(negedge clk);
        tms = t; tdi = di; tdo = dq;
        repeat (3) @(negedge clk);
        tck = 1'b1;
        nxt = ref_next(m_state, t);
        shift = (m_state == 4'd4) || (m_state == 4'd11);
        q_st.push_back(nxt);
        if (shift && nxt == m_state) begin
            if (m_cnt < CAP_W) begin
                m_tdi[m_cnt] = di;
                m_tdo[m_cnt] = dq;
            end else begin
                m_ovf = 1'b1;
            end
            if (m_cnt < 255) m_cnt++;
        end else if (shift) begin
            if (!skip_next) begin
                q_ir.push_back(m_state == 4'd11);
                q_ovf.push_back(m_ovf);
                q_cnt.push_back(CNT_W'(m_cnt));
                q_tdi.push_back(m_tdi);
                q_tdo.push_back(m_tdo);
                q_tag.push_back(cur_tag);
            end
            skip_next = 1'b0;
            m_tdi = '0; m_tdo = '0; m_cnt = 0; m_ovf = 1'b0;
        end
        m_state = nxt;
        repeat (4) @(negedge clk);
        tck = 1'b0;
    endtask

    function automatic logic pat_bit(int seed, int i);
        return seed[i % 32] ^ ((i / 32) % 2 == 1);
    endfunction

    // From Run-Test/Idle: a scan of n bits, back to Run-Test/Idle
    task automatic scan(bit ir, int n, int seed);
        tck_edge(1, 0, 0);
        if (ir) tck_edge(1, 0, 0);
        tck_edge(0, 0, 0);
        tck_edge(0, 1, 1);              // enters shift, not captured
        for (int i = 0; i < n; i++)
            tck_edge(0, pat_bit(seed, i), ~pat_bit(seed, i) ^ i[1]);
        tck_edge(1, 1, 0);              // leaves shift, not captured
        tck_edge(1, 0, 0);
        tck_edge(0, 0, 0);
    endtask

    // Monitor: compares strobes and accepted records
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                if (st_valid) begin
                    strobes++;
                    if (q_st.size() == 0) check("R4", "unexpected strobe", 1, 0);
                    else check("R2", "state code", CAP_W'(st_code), CAP_W'(q_st.pop_front()));
                end
                if (rec_valid && ready) begin
                    if (q_tag.size() == 0) begin
                        check("R7", "unexpected record", 1, 0);
                    end else begin
                        string tg;
                        tg = q_tag.pop_front();
                        check(tg, "ir flag",   CAP_W'(rec_is_ir), CAP_W'(q_ir.pop_front()));
                        check(tg, "ovf flag",  CAP_W'(rec_ovf),   CAP_W'(q_ovf.pop_front()));
                        check(tg, "bit count", CAP_W'(rec_count), CAP_W'(q_cnt.pop_front()));
                        check(tg, "tdi bits",  rec_tdi, q_tdi.pop_front());
                        check(tg, "tdo bits",  rec_tdo, q_tdo.pop_front());
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int base;
        rst = 1'b1; tck = 0; tms = 0; tdi = 0; tdo = 0; ready = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1", "reset state", CAP_W'(st_code), 1);
        check("R1", "reset strobe", CAP_W'(st_valid), 0);
        check("R1", "reset rec_valid", CAP_W'(rec_valid), 0);
        check("R1", "reset lost", CAP_W'(rec_lost), 0);

        // R2: walk through the transition table
        cur_tag = "R2";
        tck_edge(0,0,0); tck_edge(1,0,0); tck_edge(1,0,0); tck_edge(1,0,0);
        tck_edge(1,0,0); tck_edge(0,0,0);
        tck_edge(1,0,0); tck_edge(0,0,0); tck_edge(1,0,0); // Capture-DR -> Exit1-DR: no record (R7)
        tck_edge(1,0,0); tck_edge(1,0,0); tck_edge(1,0,0); tck_edge(0,0,0);
        tck_edge(1,0,0); tck_edge(0,0,0); tck_edge(0,0,0); tck_edge(1,0,0);
        tck_edge(1,0,0); tck_edge(0,0,0);

        // R3: wiggle wires with the test clock low
        repeat (6) @(negedge clk);
        base = strobes;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            tms = i[0]; tdi = i[1]; tdo = i[2];
        end
        repeat (8) @(negedge clk); #1;
        check("R3", "strobes while test clock steady", CAP_W'(strobes - base), 0);
        check("R3", "state while test clock steady", CAP_W'(st_code), 1);

        // R4: unchanged-state edges still strobe
        base = strobes;
        tck_edge(0,0,0); tck_edge(0,1,0); tck_edge(0,0,1);
        repeat (6) @(negedge clk); #1;
        check("R4", "strobes for three idle edges", CAP_W'(strobes - base), 3);

        // R6: bit ordering, data scan
        cur_tag = "R6";
        scan(0, 8, 32'h0000_00A5);

        // R5: scan split around Pause
        cur_tag = "R5";
        tck_edge(1,0,0); tck_edge(0,0,0); tck_edge(0,1,1);
        tck_edge(0,1,0); tck_edge(0,0,1); tck_edge(0,1,1);
        tck_edge(1,0,0); tck_edge(0,1,1); tck_edge(1,1,1);
        tck_edge(0,1,1);                      // Exit2 -> Shift, not captured
        tck_edge(0,0,1); tck_edge(0,1,0);
        tck_edge(1,1,1); tck_edge(1,0,0); tck_edge(0,0,0);

        // R7: instruction scan
        cur_tag = "R7";
        scan(1, 5, 32'h0000_0016);

        // R10: zero-length scan
        cur_tag = "R10";
        scan(0, 0, 0);

        // R8: overflow and count saturation
        cur_tag = "R8";
        scan(0, 70, 32'h1234_5678);
        scan(1, 300, 32'h9E37_79B9);

        // R9: consumer stalls, second record is dropped
        cur_tag = "R9";
        ready = 1'b0;
        scan(0, 4, 32'h0000_000C);
        skip_next = 1'b1;
        scan(1, 3, 32'h0000_0005);
        repeat (4) @(negedge clk); #1;
        check("R9", "lost flag after collision", CAP_W'(rec_lost), 1);
        check("R9", "first record still pending", CAP_W'(rec_valid), 1);
        check("R9", "pending record is the first", CAP_W'(rec_count), 4);
        @(negedge clk);
        ready = 1'b1;
        repeat (4) @(negedge clk);
        scan(0, 2, 32'h0000_0002);
        repeat (10) @(negedge clk); #1;
        check("R9", "lost flag sticky", CAP_W'(rec_lost), 1);

        check("R7", "records left unseen", CAP_W'(q_tag.size()), 0);
        check("R4", "strobes left unseen", CAP_W'(q_st.size()), 0);
        report();
    end
endmodule